// File: doc/BRIEF.md
# Cascadable Ripple Magnitude Comparator

This block compares two unsigned binary operands of a parameterized even width and reports all six relations between them: equal, not equal, less, less-or-equal, greater and greater-or-equal. It is purely combinational. The operands are cut into two-bit pairs, and one identical slice handles each pair. The decision travels from the most significant pair toward the least significant one, much like a carry chain running the other way. Each slice hands a "less so far" flag and an "equal so far" flag to the slice below it. Once a higher pair differs, that pair fixes the answer and no lower pair can change it.

Three cascade inputs (less, equal, greater) break ties when every pair matches. To build a wider comparator, feed a less-significant instance's less, equal and greater outputs into the cascade inputs of the next more-significant instance. No gates are needed between instances. A stand-alone instance ties the equal cascade input high and the other two low.

Top module: `mag_cmp_cascade`

## Requirements
- R1: With the cascade tied to equal (equal=1, less=0, greater=0), lt_o is 1 exactly when X < Y as unsigned numbers.
- R2: With the cascade tied to equal, eq_o is 1 exactly when X == Y.
- R3: With the cascade tied to equal, gt_o is 1 exactly when X > Y as unsigned numbers.
- R4: When the upper half of X differs from the upper half of Y, the result follows the comparison of the upper halves alone, whatever the lower halves hold.
- R5: When X == Y, lt_o, eq_o and gt_o copy casc_lt_i, casc_eq_i and casc_gt_i respectively.
- R6: ne_o is always the inverse of eq_o, and it is 1 whenever X differs from Y.
- R7: le_o equals lt_o OR eq_o, and ge_o equals gt_o OR eq_o.
- R8: When exactly one cascade input is 1, exactly one of lt_o, eq_o and gt_o is 1.
- R9: Two 16-bit instances chained (low instance's lt/eq/gt outputs into the high instance's cascade inputs) give the same six results as one 32-bit instance on the same operands.
- R10: WIDTH must be even; the block is built from WIDTH/2 two-bit slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | Left operand X, unsigned |
| y_i | input | WIDTH | Right operand Y, unsigned |
| casc_lt_i | input | 1 | Tie-break from a less-significant stage: lower part reports less |
| casc_eq_i | input | 1 | Tie-break from a less-significant stage: lower part reports equal |
| casc_gt_i | input | 1 | Tie-break from a less-significant stage: lower part reports greater |
| eq_o | output | 1 | X equals Y (with tie-break) |
| ne_o | output | 1 | X differs from Y (with tie-break) |
| lt_o | output | 1 | X less than Y |
| le_o | output | 1 | X less than or equal to Y |
| gt_o | output | 1 | X greater than Y |
| ge_o | output | 1 | X greater than or equal to Y |

## Verification
Two decision sources can be active in the same evaluation: the slice chain's own verdict and the cascade tie-break. The cascade must win only when every pair matches, and it must be ignored otherwise. The bench provokes this overlap by setting the cascade inputs to a value that contradicts the operand order, both on unequal operands and on equal ones. It then judges the outputs against a reference function in which the cascade matters only under equality. The same overlap is checked again at the seam of two chained 16-bit instances, where the low instance's result acts as the high instance's tie-break.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Per-pair verdict carried down the chain.
  typedef struct packed {
    logic lt;
    logic eq;
  } rel_t;

  // Single-bit primitives.
  function automatic logic bit_lt(input logic xb, input logic yb);
    return ~xb & yb;
  endfunction

  function automatic logic bit_eq(input logic xb, input logic yb);
    return ~(xb ^ yb);
  endfunction

  // Two-bit compare built from the single-bit primitives: the upper bit decides first.
  function automatic rel_t pair_rel(input logic [1:0] xp, input logic [1:0] yp);
    rel_t r;
    r.lt = bit_lt(xp[1], yp[1]) | (bit_eq(xp[1], yp[1]) & bit_lt(xp[0], yp[0]));
    r.eq = bit_eq(xp[1], yp[1]) & bit_eq(xp[0], yp[0]);
    return r;
  endfunction

  // Combining a verdict from above with a local verdict.
  function automatic rel_t chain_step(input rel_t above, input rel_t local_r);
    rel_t r;
    r.lt = above.lt | (above.eq & local_r.lt);
    r.eq = above.eq & local_r.eq;
    return r;
  endfunction

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
(
  input  logic [1:0] xp_i,
  input  logic [1:0] yp_i,
  input  logic       lt_in,
  input  logic       eq_in,
  output logic       lt_out,
  output logic       eq_out
);

  rel_t local_r;
  rel_t above_r;
  rel_t next_r;

  assign local_r  = pair_rel(xp_i, yp_i);
  assign above_r  = '{lt: lt_in, eq: eq_in};
  assign next_r   = chain_step(above_r, local_r);
  assign lt_out   = next_r.lt;
  assign eq_out   = next_r.eq;

  // Once the upper pairs differ, this slice must only forward their verdict.
  always_comb begin
    if (!eq_in) begin
      assert_upper_decides_R4: assert (lt_out == lt_in && !eq_out)
        else $error("slice changed a settled verdict");
    end
  end

  // Equal-so-far only when both the pairs above and this pair match.
  always_comb begin
    if (eq_out) begin
      assert_slice_eq_R2: assert (eq_in && (xp_i == yp_i))
        else $error("slice reports equal on differing pair");
    end
  end

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic             chain_lt_o,
  output logic             chain_eq_o
);

  localparam int NSLICE = WIDTH / 2;

  // R10: the operands must split into whole two-bit pairs.
  if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_width_bad
    $error("cmp_chain: WIDTH must be even and at least 2");
  end

  // Index NSLICE is the entry above the top pair; index 0 leaves the bottom pair.
  logic [NSLICE:0] lt_c;
  logic [NSLICE:0] eq_c;

  assign lt_c[NSLICE] = 1'b0;
  assign eq_c[NSLICE] = 1'b1;

  for (genvar s = NSLICE - 1; s >= 0; s--) begin : g_slice
    cmp_slice u_slice (
      .xp_i   (x_i[2*s+1 -: 2]),
      .yp_i   (y_i[2*s+1 -: 2]),
      .lt_in  (lt_c[s+1]),
      .eq_in  (eq_c[s+1]),
      .lt_out (lt_c[s]),
      .eq_out (eq_c[s])
    );
  end

  assign chain_lt_o = lt_c[0];
  assign chain_eq_o = eq_c[0];

  // The chain never claims both less and equal at once.
  always_comb begin
    assert_chain_exclusive_R8: assert (!(chain_lt_o && chain_eq_o))
      else $error("chain reports less and equal together");
  end

endmodule

// File: rtl/cmp_merge.sv
module cmp_merge (
  input  logic chain_lt_i,
  input  logic chain_eq_i,
  input  logic casc_lt_i,
  input  logic casc_eq_i,
  input  logic casc_gt_i,
  output logic lt_o,
  output logic eq_o,
  output logic gt_o
);

  logic chain_gt;

  assign chain_gt = ~chain_lt_i & ~chain_eq_i;
  assign lt_o     = chain_lt_i | (chain_eq_i & casc_lt_i);
  assign eq_o     = chain_eq_i & casc_eq_i;
  assign gt_o     = chain_gt   | (chain_eq_i & casc_gt_i);

  // When the chain sees a tie, the cascade value must pass through unchanged.
  always_comb begin
    if (chain_eq_i) begin
      assert_tie_passes_R5: assert ({lt_o, eq_o, gt_o} == {casc_lt_i, casc_eq_i, casc_gt_i})
        else $error("cascade tie-break not forwarded");
    end
  end

endmodule

// File: rtl/cmp_relations.sv
module cmp_relations (
  input  logic lt_i,
  input  logic eq_i,
  input  logic gt_i,
  output logic eq_o,
  output logic ne_o,
  output logic lt_o,
  output logic le_o,
  output logic gt_o,
  output logic ge_o
);

  assign eq_o = eq_i;
  assign ne_o = ~eq_i;
  assign lt_o = lt_i;
  assign le_o = lt_i | eq_i;
  assign gt_o = gt_i;
  assign ge_o = gt_i | eq_i;

endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             casc_lt_i,
  input  logic             casc_eq_i,
  input  logic             casc_gt_i,
  output logic             eq_o,
  output logic             ne_o,
  output logic             lt_o,
  output logic             le_o,
  output logic             gt_o,
  output logic             ge_o
);

  logic chain_lt;
  logic chain_eq;
  logic m_lt;
  logic m_eq;
  logic m_gt;

  cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i        (x_i),
    .y_i        (y_i),
    .chain_lt_o (chain_lt),
    .chain_eq_o (chain_eq)
  );

  cmp_merge u_merge (
    .chain_lt_i (chain_lt),
    .chain_eq_i (chain_eq),
    .casc_lt_i  (casc_lt_i),
    .casc_eq_i  (casc_eq_i),
    .casc_gt_i  (casc_gt_i),
    .lt_o       (m_lt),
    .eq_o       (m_eq),
    .gt_o       (m_gt)
  );

  cmp_relations u_rel (
    .lt_i (m_lt),
    .eq_i (m_eq),
    .gt_i (m_gt),
    .eq_o (eq_o),
    .ne_o (ne_o),
    .lt_o (lt_o),
    .le_o (le_o),
    .gt_o (gt_o),
    .ge_o (ge_o)
  );

  logic casc_onehot;
  assign casc_onehot = $onehot({casc_lt_i, casc_eq_i, casc_gt_i});

  always_comb begin
    if (casc_onehot) begin
      assert_one_verdict_R8: assert ($onehot({lt_o, eq_o, gt_o}))
        else $error("verdict not one-hot");
    end
  end

  always_comb begin
    if (eq_o) begin
      assert_eq_needs_match_R2: assert (x_i == y_i)
        else $error("equal reported on differing operands");
    end
  end

  always_comb begin
    if (x_i != y_i) begin
      assert_ne_on_mismatch_R6: assert (ne_o)
        else $error("not-equal missing on differing operands");
    end
  end

  always_comb begin
    if (casc_eq_i && !casc_lt_i && !casc_gt_i && lt_o) begin
      assert_lt_order_R1: assert (x_i < y_i)
        else $error("less reported against unsigned order");
    end
  end

endmodule

// File: tb/mag_cmp_cascade_test.sv
`timescale 1ns/1ps
module mag_cmp_cascade_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // 8-bit unit for the exhaustive sweep.
  logic [7:0] x8, y8;
  logic cl8, ce8, cg8;
  logic eq8, ne8, lt8, le8, gt8, ge8;

  mag_cmp_cascade #(.WIDTH(8)) uut (
    .x_i(x8), .y_i(y8), .casc_lt_i(cl8), .casc_eq_i(ce8), .casc_gt_i(cg8),
    .eq_o(eq8), .ne_o(ne8), .lt_o(lt8), .le_o(le8), .gt_o(gt8), .ge_o(ge8)
  );

  // 32-bit unit, and two chained 16-bit units on the same operands.
  logic [31:0] xw, yw;
  logic clw, cew, cgw;
  logic eqw, new_, ltw, lew, gtw, gew;

  mag_cmp_cascade #(.WIDTH(32)) uut_wide (
    .x_i(xw), .y_i(yw), .casc_lt_i(clw), .casc_eq_i(cew), .casc_gt_i(cgw),
    .eq_o(eqw), .ne_o(new_), .lt_o(ltw), .le_o(lew), .gt_o(gtw), .ge_o(gew)
  );

  logic lo_eq, lo_ne, lo_lt, lo_le, lo_gt, lo_ge;
  logic hi_eq, hi_ne, hi_lt, hi_le, hi_gt, hi_ge;

  mag_cmp_cascade #(.WIDTH(16)) uut_lo (
    .x_i(xw[15:0]), .y_i(yw[15:0]), .casc_lt_i(clw), .casc_eq_i(cew), .casc_gt_i(cgw),
    .eq_o(lo_eq), .ne_o(lo_ne), .lt_o(lo_lt), .le_o(lo_le), .gt_o(lo_gt), .ge_o(lo_ge)
  );

  mag_cmp_cascade #(.WIDTH(16)) uut_hi (
    .x_i(xw[31:16]), .y_i(yw[31:16]), .casc_lt_i(lo_lt), .casc_eq_i(lo_eq), .casc_gt_i(lo_gt),
    .eq_o(hi_eq), .ne_o(hi_ne), .lt_o(hi_lt), .le_o(hi_le), .gt_o(hi_gt), .ge_o(hi_ge)
  );

  // Reference: operand order decides; the tie-break only under equality. Returns {lt,eq,gt}.
  function automatic logic [2:0] ref_rel(input logic [31:0] a, input logic [31:0] b,
                                         input logic [2:0] casc);
    if (a < b)      return 3'b100;
    else if (a > b) return 3'b001;
    else            return casc;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b (x=%0h y=%0h)", tag, act, exp,
               (tag == "R9") ? xw : {24'd0, x8}, (tag == "R9") ? yw : {24'd0, y8});
    end
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic [2:0] casc);
    @(posedge clk);
    x8 <= a; y8 <= b; {cl8, ce8, cg8} <= casc;
    @(negedge clk);
  endtask

  task automatic judge8(input logic [2:0] casc);
    logic [2:0] e;
    e = ref_rel({24'd0, x8}, {24'd0, y8}, casc);
    chk("R1", lt8, e[2]);
    chk("R2", eq8, e[1]);
    chk("R3", gt8, e[0]);
    chk("R6", ne8, ~e[1]);
    chk("R7", le8, e[2] | e[1]);
    chk("R7", ge8, e[0] | e[1]);
    if ($onehot(casc)) chk("R8", $onehot({lt8, eq8, gt8}), 1'b1);
  endtask

  task automatic run_wide(input logic [31:0] a, input logic [31:0] b, input logic [2:0] casc);
    logic [2:0] e;
    @(posedge clk);
    xw <= a; yw <= b; {clw, cew, cgw} <= casc;
    @(negedge clk);
    e = ref_rel(a, b, casc);
    chk("R1", ltw, e[2]);
    chk("R2", eqw, e[1]);
    chk("R3", gtw, e[0]);
    chk("R6", new_, ~e[1]);
    chk("R7", lew, e[2] | e[1]);
    chk("R7", gew, e[0] | e[1]);
    // R9: the chained pair must agree with the wide unit.
    chk("R9", hi_lt, e[2]);
    chk("R9", hi_eq, e[1]);
    chk("R9", hi_gt, e[0]);
    chk("R9", hi_le, e[2] | e[1]);
    chk("R9", hi_ge, e[0] | e[1]);
    chk("R9", hi_ne, ~e[1]);
  endtask

  initial begin
    x8 = '0; y8 = '0; {cl8, ce8, cg8} = 3'b010;
    xw = '0; yw = '0; {clw, cew, cgw} = 3'b010;
    void'($urandom(32'h1f3a_5c07));

    // Initial state: zero operands with the cascade at equal report equal.
    @(negedge clk);
    chk("R2", eq8, 1'b1);
    chk("R6", ne8, 1'b0);

    // R1 R2 R3 R6 R7 R8: every 8-bit pair with the cascade at equal (R10: 4 slices).
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive8(a[7:0], b[7:0], 3'b010);
        judge8(3'b010);
      end
    end

    // R5: equal operands forward a contradicting tie-break; unequal ones ignore it.
    for (int k = 0; k < 256; k++) begin
      logic [7:0] v;
      v = k[7:0];
      drive8(v, v, 3'b100); chk("R5", lt8, 1'b1); chk("R5", eq8, 1'b0); judge8(3'b100);
      drive8(v, v, 3'b001); chk("R5", gt8, 1'b1); chk("R5", eq8, 1'b0); judge8(3'b001);
      if (v != 8'hff) begin
        drive8(v, v + 8'd1, 3'b001); chk("R5", lt8, 1'b1); judge8(3'b001);
      end
    end

    // R4: top halves differ, bottom halves random; only the top halves may count.
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (a[31:16] == b[31:16]) b[31:16] = a[31:16] ^ 16'h0100;
      run_wide(a, b, 3'b010);
      chk("R4", ltw, a[31:16] < b[31:16]);
      chk("R4", gtw, a[31:16] > b[31:16]);
    end

    // Directed corners at 32 bits.
    run_wide(32'h0000_0000, 32'hffff_ffff, 3'b010);
    run_wide(32'hffff_ffff, 32'h0000_0000, 3'b010);
    run_wide(32'h8000_0000, 32'h7fff_ffff, 3'b010);
    run_wide(32'hdead_beef, 32'hdead_beef, 3'b100);
    run_wide(32'hdead_beef, 32'hdead_beef, 3'b001);
    run_wide(32'h1234_0000, 32'h1234_0001, 3'b001);

    // Random 32-bit, with high halves often equal so the chained seam is exercised.
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] a, b;
      logic [2:0] c;
      a = $urandom; b = $urandom;
      case ($urandom_range(0, 3))
        0: b[31:16] = a[31:16];
        1: b = a;
        2: b = a ^ (32'd1 << $urandom_range(0, 31));
        default: ;
      endcase
      case ($urandom_range(0, 2))
        0: c = 3'b100;
        1: c = 3'b001;
        default: c = 3'b010;
      endcase
      run_wide(a, b, c);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule